// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a synchronous request/acknowledge host port to one external asynchronous static RAM of 128K words by 8 bits. The host offers a read or write with a 17-bit word address and 8-bit data. The controller takes it when `busy` is low and drives the memory's control pins from a small state machine. That memory has an active-low select, an active-high select, an active-low write strobe and an active-low output enable. The controller holds each access open for a number of clock cycles derived from the memory's access time. It then raises `done` for one cycle, with read data on `rd_data`.

The data bus is split at the pins into an input path, an output path and an output-enable, so the pad ring can build the tristate driver. A `standby` input places the memory in its low-power retention state by deselecting both chip selects. Requests that arrive while standby is in force are held off with `busy`.

Top module: `sram_ctrl`

## Requirements
- R1: After reset the memory is selected (`mem_ce_n`=0, `mem_ce`=1), `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `busy`=0 and `done`=0.
- R2: A request is taken on a rising clock edge where `req_valid`=1 and `busy`=0. `busy` is high from the next cycle, and `mem_addr` shows the request's address for the whole access.
- R3: A read (`req_write`=0) holds `mem_oe_n` low for exactly WAIT cycles with `mem_we_n` high and the driver off. `rd_data` takes the value on `mem_dq_in` at the end of the last of those cycles.
- R4: A write (`req_write`=1) holds `mem_we_n` low for exactly WAIT cycles. Through that window `mem_oe_n` stays high, `mem_dq_oe`=1 and `mem_dq_out` equals the request's data.
- R5: On a write, `mem_we_n` returns high one cycle before the data driver is released. In that hold cycle `mem_dq_oe`, `mem_dq_out` and `mem_addr` keep their values.
- R6: WAIT equals the access time divided by the clock period, rounded up (55000 ps over 10000 ps gives 6).
- R7: `mem_oe_n` and `mem_we_n` are never low together, and `mem_dq_oe` is never 1 while `mem_oe_n` is low.
- R8: `mem_we_n` never falls in the cycle right after one where `mem_oe_n` was low. A read followed by a write always has at least one cycle with both high.
- R9: Each request gives exactly one `done` pulse, one cycle wide, WAIT+1 cycles after the accepting edge. `busy` is low in the cycle after the pulse.
- R10: `rd_data` changes only in the cycle where `done` for a read is high.
- R11: `mem_ce` is always the inverse of `mem_ce_n`. With `standby`=1 and no access in progress, the next cycle has `mem_ce_n`=1, `mem_ce`=0, both strobes high and the driver off.
- R12: `busy` is 1 whenever `standby` is 1, and no access starts then. After `standby` falls, the memory is reselected and `busy` drops one cycle later, and a waiting request is then taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| standby | input | 1 | Request low-power retention |
| busy | output | 1 | Controller cannot take a request |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | 8 | Last read data |
| mem_addr | output | 17 | Memory address pins |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data to the memory |
| mem_dq_oe | output | 1 | Enable for the data driver |
| mem_dq_in | input | 8 | Data from the memory |

## Verification
The properties assume that the host presents a request only through `req_valid` and does not depend on fields after the accepting edge. They also assume that the memory has valid data by the end of the WAIT-th output-enable cycle. The bench's memory model honours the second assumption strictly: it returns a marker byte until WAIT-1 edges of a read have passed, so sampling one cycle early is visible. The stimulus drives inputs only at falling edges and withdraws `req_valid` right after acceptance. Standby is raised only while the controller is idle, or with a request already waiting.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_STBY  = 3'd1,
    ST_RD    = 3'd2,
    ST_TURN  = 3'd3,
    ST_WR    = 3'd4,
    ST_WHOLD = 3'd5
  } sc_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
  parameter int WAIT_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic last
);
  localparam int CNT_W = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(WAIT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  // Count access cycles; restart at zero whenever not counting
  always_comb begin
    last  = en && (cnt_q == LAST_VAL);
    cnt_d = (en && !last) ? cnt_q + CNT_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic standby,
  input  logic last,
  output logic accept,
  output logic capture,
  output logic cnt_en,
  output logic busy,
  output logic done,
  output logic ce_n,
  output logic ce,
  output logic we_n,
  output logic oe_n,
  output logic dq_oe
);
  sc_state_e st_q;
  sc_state_e st_d;
  logic      done_q;
  logic      done_d;

  always_comb begin
    st_d   = st_q;
    accept = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (standby) begin
          st_d = ST_STBY;
        end else if (req_valid) begin
          accept = 1'b1;
          st_d   = req_write ? ST_WR : ST_RD;
        end
      end
      ST_STBY:  if (!standby) st_d = ST_IDLE;
      ST_RD:    if (last) st_d = ST_TURN;
      ST_TURN:  st_d = ST_IDLE;
      ST_WR:    if (last) st_d = ST_WHOLD;
      ST_WHOLD: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cnt_en  = (st_q == ST_RD) || (st_q == ST_WR);
    capture = (st_q == ST_RD) && last;
    done_d  = cnt_en && last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  // Pin decode straight from the state register
  always_comb begin
    busy  = (st_q != ST_IDLE) || standby;
    done  = done_q;
    ce_n  = (st_q == ST_STBY);
    ce    = (st_q != ST_STBY);
    we_n  = (st_q != ST_WR);
    oe_n  = (st_q != ST_RD);
    dq_oe = (st_q == ST_WR) || (st_q == ST_WHOLD);
  end
endmodule

// File: rtl/sram_dp_regs.sv
module sram_dp_regs #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rd_q
);
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d;
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    addr_d  = accept  ? req_addr  : addr_q;
    wdata_d = accept  ? req_wdata : wdata_q;
    rd_d    = capture ? dq_in     : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      rd_q    <= rd_d;
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int ACCESS_PS     = 55000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              standby,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int WAIT_RAW = ceil_div(ACCESS_PS, CLK_PERIOD_PS);
  localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;

  logic accept;
  logic capture;
  logic cnt_en;
  logic last;

  sram_wait_cnt #(.WAIT_CYC(WAIT_CYC)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cnt_en),
    .last  (last)
  );

  sram_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .standby   (standby),
    .last      (last),
    .accept    (accept),
    .capture   (capture),
    .cnt_en    (cnt_en),
    .busy      (busy),
    .done      (done),
    .ce_n      (mem_ce_n),
    .ce        (mem_ce),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .dq_oe     (mem_dq_oe)
  );

  sram_dp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_in     (mem_dq_in),
    .addr_q    (mem_addr),
    .wdata_q   (mem_dq_out),
    .rd_q      (rd_data)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int WAIT_CYC = 6,
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              standby,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rd_data,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  logic [15:0] we_low_q;
  logic [15:0] oe_low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_q <= '0;
      oe_low_q <= '0;
    end else begin
      we_low_q <= mem_we_n ? 16'd0 : we_low_q + 16'd1;
      oe_low_q <= mem_oe_n ? 16'd0 : oe_low_q + 16'd1;
    end
  end

  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !standby) |=> busy);
  a_r3_oe_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_low_q == 16'(WAIT_CYC)));
  a_r4_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_q == 16'(WAIT_CYC)));
  a_r5_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_out)));
  a_r7_no_oe_we: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  a_r7_no_drive_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  a_r8_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(mem_oe_n));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_rd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> done);
  a_r11_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_we_n && mem_oe_n && !mem_dq_oe));
  a_r12_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> busy);
endmodule

bind sram_ctrl sram_ctrl_chk #(
  .WAIT_CYC (WAIT_CYC),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .standby    (standby),
  .busy       (busy),
  .done       (done),
  .rd_data    (rd_data),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;
  localparam int BW = (55000 + 10000 - 1) / 10000;  // expected wait cycles

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        standby = 1'b0;
  logic        busy, done;
  logic [7:0]  rd_data;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int n_chk = 0;
  int n_fail = 0;
  int n_done = 0;
  int n_req = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sram_ctrl #(.CLK_PERIOD_PS(10000), .ACCESS_PS(55000)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .standby(standby),
    .busy(busy), .done(done), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [16:0] adr(input int i);
    return {7'(i * 37 + 5), 10'(i * 13)};
  endfunction

  function automatic logic [7:0] dat(input int i);
    return 8'(i * 29 + 3);
  endfunction

  // Memory model: data valid only after BW-1 edges of output enable
  logic [7:0]  mem [0:1023];
  int          wl = 0;
  int          ra = 0;
  logic [7:0]  wd;
  logic [16:0] wa;
  wire reading = !mem_ce_n && mem_ce && !mem_oe_n && mem_we_n;

  assign mem_dq_in = (reading && ra >= BW - 1) ? mem[mem_addr[9:0]] : 8'hEE;

  always @(posedge clk) begin
    if (rst_n) begin
      if (!mem_we_n) begin
        if (wl == 0) begin
          wd <= mem_dq_out;
          wa <= mem_addr;
        end else begin
          chk(mem_dq_out == wd && mem_addr == wa, "R4 data stable", mem_dq_out, wd);
        end
        chk(mem_dq_oe && mem_oe_n, "R4 driver on", {mem_dq_oe, mem_oe_n}, 3);
        wl <= wl + 1;
      end else if (wl != 0) begin
        chk(wl == BW, "R4 we width", wl, BW);
        chk(mem_dq_oe && mem_dq_out == wd && mem_addr == wa, "R5 hold",
            {mem_dq_oe, mem_dq_out}, {1'b1, wd});
        mem[wa[9:0]] <= wd;
        wl <= 0;
      end
      if (reading) begin
        ra <= ra + 1;
      end else if (ra != 0) begin
        chk(ra == BW, "R3 oe width", ra, BW);
        ra <= 0;
      end
    end
  end

  // Pin rules every cycle
  bit prev_oe_low = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(!mem_oe_n && !mem_we_n) && !(mem_dq_oe && !mem_oe_n), "R7",
          {mem_oe_n, mem_we_n, mem_dq_oe}, 0);
      chk(mem_ce == !mem_ce_n, "R11 polarity", {mem_ce, mem_ce_n}, {!mem_ce_n, mem_ce_n});
      if (!mem_we_n) chk(!prev_oe_low, "R8 turnaround", prev_oe_low, 0);
      prev_oe_low = !mem_oe_n;
      if (done) n_done++;
    end
  end

  task automatic do_req(input bit wr, input logic [16:0] a, input logic [7:0] d,
                        output logic [7:0] rv);
    int lat;
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;
    req_wdata = ~d;
    n_req++;
    chk(busy == 1'b1, "R2 busy", busy, 1);
    chk(mem_addr == a, "R2 addr", mem_addr, a);
    lat = 1;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
      if (!done) chk(mem_addr == a, "R2 addr held", mem_addr, a);
    end
    chk(lat == BW + 1, "R9 R6 latency", lat, BW + 1);
    rv = rd_data;
    @(negedge clk);
    chk(!done && !busy, "R9 single pulse", {done, busy}, 0);
  endtask

  initial begin
    logic [7:0] rv;
    logic [7:0] keep;
    repeat (3) @(negedge clk);
    chk(mem_ce_n == 0 && mem_ce == 1 && mem_we_n && mem_oe_n && !mem_dq_oe && !busy && !done,
        "R1 reset", {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe, busy, done}, 7'b0111000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1 after release", {busy, done}, 0);

    for (int i = 0; i < 32; i++) do_req(1'b1, adr(i), dat(i), rv);
    for (int i = 0; i < 32; i++) begin
      do_req(1'b0, adr(i), 8'h00, rv);
      chk(rv == dat(i), "R3 read data", rv, dat(i));
    end
    // write then read back, and read followed at once by a write
    for (int i = 32; i < 64; i++) begin
      do_req(1'b1, adr(i), dat(i), rv);
      do_req(1'b0, adr(i), 8'h00, rv);
      chk(rv == dat(i), "R3 readback", rv, dat(i));
      do_req(1'b0, adr(i - 32), 8'h00, rv);
      chk(rv == dat(i - 32), "R3 R8 read before write", rv, dat(i - 32));
      do_req(1'b1, adr(i - 32), dat(i - 32) ^ 8'h5A, rv);
    end
    do_req(1'b0, adr(7), 8'h00, rv);
    chk(rv == (dat(7) ^ 8'h5A), "R3 overwritten", rv, dat(7) ^ 8'h5A);

    // R10: write does not disturb read data
    keep = rd_data;
    do_req(1'b1, adr(9), 8'h11, rv);
    repeat (4) @(negedge clk);
    chk(rd_data == keep, "R10 rd_data stable", rd_data, keep);

    // Standby
    @(negedge clk);
    standby = 1'b1;
    #1 chk(busy == 1'b1, "R12 busy at once", busy, 1);
    @(negedge clk);
    chk(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe, "R11 deselected",
        {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
    req_valid = 1'b1;
    req_write = 1'b0;
    req_addr  = adr(40);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(busy && mem_oe_n && mem_ce_n && !done, "R12 held off",
          {busy, mem_oe_n, mem_ce_n, done}, 4'b1110);
    end
    standby = 1'b0;
    @(negedge clk);
    chk(!mem_ce_n && mem_ce && !busy, "R12 reselect", {mem_ce_n, mem_ce, busy}, 3'b010);
    @(negedge clk);
    req_valid = 1'b0;
    n_req++;
    chk(busy && !mem_oe_n, "R12 accepted", {busy, mem_oe_n}, 2'b10);
    while (!done) @(negedge clk);
    chk(rd_data == dat(40), "R12 R3 read after standby", rd_data, dat(40));
    repeat (3) @(negedge clk);
    chk(n_done == n_req, "R9 done count", n_done, n_req);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule